// File: doc/BRIEF.md
# Processor-Bus to I/O Port Window Translator

This block sits between a 32-bit processor bus and a 16-bit I/O port space. Every bus request is decoded in the same cycle it arrives. A request that falls inside an 8 MB I/O window is passed on to the I/O side with a translated port number. Its access size, direction and data go with it, and the data bytes are reordered when the system runs big-endian. Read data coming back from the I/O side goes through the same reordering before it returns to the bus.

Two port-numbering schemes can be chosen with a mode input. In the flat scheme the port number is taken directly from the low address bits. In the sparse scheme, successive ports are spread over 4 KB pages, and the page index is folded back into the port number together with the low five address bits.

A separate 4-byte location returns an interrupt vector that is supplied from outside. A request that matches neither this location nor the window is flagged as an error.

Top module: `io_window_xlate`

## Requirements
- R1: A valid request with address in [0x8000_0000, 0x8080_0000) raises io_hit_o in the same cycle, with io_write_o equal to req_write_i and io_size_o equal to req_size_i. Any other request leaves io_hit_o, io_write_o, io_size_o, io_addr_o and io_wdata_o at 0.
- R2: With map_sparse_i = 0, io_addr_o equals address bits [15:0].
- R3: With map_sparse_i = 1, io_addr_o equals {address[22:12], address[4:0]}. This is the page bits shifted right by 7, ORed with the low five bits.
- R4: Size codes are 0 = byte, 1 = halfword, 2 = word, and code 3 is treated as a word. In big-endian mode, a halfword moves as {d[7:0], d[15:8]} and a word has all four bytes reversed. This applies both to io_wdata_o and to read data returned on rsp_rdata_o. In little-endian mode, data passes through unchanged.
- R5: Byte accesses are never reordered. For all sizes, data lanes above the access size are driven to 0 in both directions.
- R6: The endianness input cfg_big_endian_i is captured while rst_ni is low. Changes to it after reset is released have no effect.
- R7: A read at 0xBFFF_FFF0 returns iack_vector_i, reordered as in R4. A read at 0xBFFF_FFF1 to 0xBFFF_FFF3 returns 0. A write anywhere in those four bytes returns rsp_rdata_o = 0, raises no error and reaches no I/O port.
- R8: A valid request that hits neither the window nor the vector location raises rsp_err_o and returns rsp_rdata_o = 0xFFFF_FFFF.
- R9: A window read returns io_rdata_i on rsp_rdata_o. A window write returns 0. With req_valid_i low, rsp_err_o is 0 and rsp_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration register |
| rst_ni | input | 1 | Active-low reset; endianness is captured while low |
| cfg_big_endian_i | input | 1 | Byte order setting, 1 = big-endian |
| map_sparse_i | input | 1 | Port numbering scheme, 1 = sparse |
| req_valid_i | input | 1 | Bus request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Bus address |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 32 | Bus write data |
| rsp_rdata_o | output | 32 | Read data returned to the bus |
| rsp_err_o | output | 1 | Request hit no decoded region |
| io_hit_o | output | 1 | Request forwarded to the I/O side |
| io_write_o | output | 1 | Direction of the forwarded access |
| io_size_o | output | 2 | Size of the forwarded access |
| io_addr_o | output | 16 | Translated port number |
| io_wdata_o | output | 32 | Reordered write data for the I/O side |
| io_rdata_i | input | 32 | Read data from the I/O side |
| iack_vector_i | input | 32 | Interrupt vector from the interrupt controller |

## Verification
The assertions assume that the request inputs settle before each sampling edge. They treat size code 3 like a word, so none of them needs that code excluded. They also take the endianness held since reset as the only byte-order setting, and do not follow cfg_big_endian_i after reset. The stimulus uses only size codes 0 to 2. It toggles cfg_big_endian_i after reset only to show that the change is ignored, and otherwise changes that input only around a reset pulse. Addresses are drawn from the window, from the four vector bytes and from the whole 32-bit range, so that hits, misses and window edges all occur.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
    localparam int BUS_AW = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic big_endian;
    } cfg_state_t;
endpackage

// File: rtl/io_win_decode.sv
module io_win_decode #(
    parameter int          AW          = 32,
    parameter int          IO_AW       = 16,
    parameter logic [31:0] WIN_BASE    = 32'h8000_0000,
    parameter int          WIN_LOG2    = 23,
    parameter logic [31:0] IACK_ADDR   = 32'hBFFF_FFF0,
    parameter int          IACK_LOG2   = 2,
    parameter int          SP_LO_W     = 5,
    parameter int          SP_PG_SHIFT = 12
) (
    input  logic [AW-1:0]    addr_i,
    input  logic             sparse_i,
    output logic             in_win_o,
    output logic             in_iack_o,
    output logic             iack_exact_o,
    output logic [IO_AW-1:0] port_o
);
    localparam int SP_PG_W = WIN_LOG2 - SP_PG_SHIFT;
    localparam int SP_W    = SP_PG_W + SP_LO_W;

    logic [SP_W-1:0]  sparse_port;
    logic [IO_AW-1:0] flat_port;

    assign in_win_o     = addr_i[AW-1:WIN_LOG2] == WIN_BASE[AW-1:WIN_LOG2];
    assign in_iack_o    = addr_i[AW-1:IACK_LOG2] == IACK_ADDR[AW-1:IACK_LOG2];
    assign iack_exact_o = in_iack_o && (addr_i[IACK_LOG2-1:0] == IACK_ADDR[IACK_LOG2-1:0]);

    assign sparse_port = {addr_i[WIN_LOG2-1:SP_PG_SHIFT], addr_i[SP_LO_W-1:0]};
    assign flat_port   = addr_i[IO_AW-1:0];

    generate
        if (SP_W == IO_AW) begin : g_sp_eq
            assign port_o = sparse_i ? sparse_port : flat_port;
        end else if (SP_W < IO_AW) begin : g_sp_narrow
            assign port_o = sparse_i ? {{(IO_AW-SP_W){1'b0}}, sparse_port} : flat_port;
        end else begin : g_sp_wide
            assign port_o = sparse_i ? sparse_port[IO_AW-1:0] : flat_port;
        end
    endgenerate
endmodule

// File: rtl/io_lane_swap.sv
module io_lane_swap
    import io_win_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] data_i,
    input  logic [1:0]    size_i,
    input  logic          big_endian_i,
    output logic [DW-1:0] data_o
);
    localparam int NB = DW / 8;

    logic [DW-1:0] word_rev;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_rev
            assign word_rev[b*8 +: 8] = data_i[(NB-1-b)*8 +: 8];
        end
    endgenerate

    always_comb begin
        data_o = '0;
        case (acc_size_e'(size_i))
            SZ_BYTE: data_o[7:0]  = data_i[7:0];
            SZ_HALF: data_o[15:0] = big_endian_i ? {data_i[7:0], data_i[15:8]} : data_i[15:0];
            default: data_o       = big_endian_i ? word_rev : data_i;
        endcase
    end
endmodule

// File: rtl/io_window_xlate.sv
module io_window_xlate
    import io_win_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
    parameter int          WIN_LOG2  = 23,
    parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0,
    parameter int          IO_AW     = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_big_endian_i,
    input  logic              map_sparse_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [31:0]       req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [31:0]       req_wdata_i,
    output logic [31:0]       rsp_rdata_o,
    output logic              rsp_err_o,
    output logic              io_hit_o,
    output logic              io_write_o,
    output logic [1:0]        io_size_o,
    output logic [IO_AW-1:0]  io_addr_o,
    output logic [31:0]       io_wdata_o,
    input  logic [31:0]       io_rdata_i,
    input  logic [31:0]       iack_vector_i
);
    cfg_state_t state_d, state_q;

    logic             in_win, in_iack, iack_exact;
    logic [IO_AW-1:0] port;
    logic [31:0]      wr_fmt, rd_src, rd_fmt;
    logic             win_acc, iack_acc;

    io_win_decode #(
        .AW(BUS_AW), .IO_AW(IO_AW), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
        .IACK_ADDR(IACK_ADDR), .IACK_LOG2(2), .SP_LO_W(5), .SP_PG_SHIFT(12)
    ) u_dec (
        .addr_i(req_addr_i), .sparse_i(map_sparse_i),
        .in_win_o(in_win), .in_iack_o(in_iack),
        .iack_exact_o(iack_exact), .port_o(port)
    );

    io_lane_swap #(.DW(DATA_W)) u_wr_swap (
        .data_i(req_wdata_i), .size_i(req_size_i),
        .big_endian_i(state_q.big_endian), .data_o(wr_fmt)
    );

    assign rd_src = in_iack ? (iack_exact ? iack_vector_i : '0) : io_rdata_i;

    io_lane_swap #(.DW(DATA_W)) u_rd_swap (
        .data_i(rd_src), .size_i(req_size_i),
        .big_endian_i(state_q.big_endian), .data_o(rd_fmt)
    );

    // configuration: only reset loads it
    always_comb begin
        state_d = state_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '{big_endian: cfg_big_endian_i};
        else         state_q <= state_d;
    end

    // request routing
    always_comb begin
        win_acc     = req_valid_i && in_win;
        iack_acc    = req_valid_i && in_iack;
        rsp_err_o   = req_valid_i && !in_win && !in_iack;
        io_hit_o    = win_acc;
        io_write_o  = win_acc && req_write_i;
        io_size_o   = win_acc ? req_size_i : 2'd0;
        io_addr_o   = win_acc ? port : '0;
        io_wdata_o  = (win_acc && req_write_i) ? wr_fmt : '0;
        if (rsp_err_o)
            rsp_rdata_o = 32'hFFFF_FFFF;
        else if ((win_acc || iack_acc) && !req_write_i)
            rsp_rdata_o = rd_fmt;
        else
            rsp_rdata_o = '0;
    end

    p_fwd_attr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        io_hit_o |-> (io_write_o == req_write_i && io_size_o == req_size_i));

    p_sparse_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (io_hit_o && map_sparse_i) |-> io_addr_o[4:0] == req_addr_i[4:0]);

    p_byte_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (io_hit_o && req_write_i && req_size_i == 2'd0)
            |-> io_wdata_o == {24'h0, req_wdata_i[7:0]});

    p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> $stable(state_q.big_endian));

    p_miss_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_err_o |-> (rsp_rdata_o == 32'hFFFF_FFFF && !io_hit_o));
endmodule

// File: tb/io_window_xlate_tb_top.sv
`timescale 1ns/1ps
module io_window_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_be = 1'b0, sparse = 1'b0;
    logic        valid = 1'b0, wr = 1'b0;
    logic [31:0] addr = '0, wdata = '0, io_rd = '0, vec = '0;
    logic [1:0]  size = '0;
    logic [31:0] rsp_rdata, io_wdata;
    logic        rsp_err, io_hit, io_write;
    logic [1:0]  io_size;
    logic [15:0] io_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    io_window_xlate dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_big_endian_i(cfg_be), .map_sparse_i(sparse),
        .req_valid_i(valid), .req_write_i(wr), .req_addr_i(addr), .req_size_i(size),
        .req_wdata_i(wdata), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
        .io_hit_o(io_hit), .io_write_o(io_write), .io_size_o(io_size),
        .io_addr_o(io_addr), .io_wdata_o(io_wdata), .io_rdata_i(io_rd),
        .iack_vector_i(vec)
    );

    function automatic logic [31:0] fmt(logic [31:0] d, logic [1:0] s, logic be);
        case (s)
            2'd0:    return {24'h0, d[7:0]};
            2'd1:    return be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
            default: return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic be);
        cfg_be = be;
        valid = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // be_model is the byte order the bench expects the block to hold
    task automatic access(logic v, logic w, logic [31:0] a, logic [1:0] s, logic [31:0] wd,
                          logic [31:0] rd, logic [31:0] vv, logic sp, logic be_model);
        logic in_win, in_iack, hit, err;
        logic [15:0] ea;
        logic [31:0] er;
        @(negedge clk);
        valid = v; wr = w; addr = a; size = s; wdata = wd; io_rd = rd; vec = vv; sparse = sp;
        #1;
        in_win  = a[31:23] == 9'h100;
        in_iack = a[31:2] == 30'h2FFF_FFFC;
        hit = v && in_win;
        err = v && !in_win && !in_iack;
        ea  = sp ? {a[22:12], a[4:0]} : a[15:0];
        if (err) er = 32'hFFFF_FFFF;
        else if (v && !w && in_win) er = fmt(rd, s, be_model);
        else if (v && !w && in_iack) er = (a[1:0] == 2'b00) ? fmt(vv, s, be_model) : 32'h0;
        else er = 32'h0;
        chk("R8", "rsp_err", {31'h0, rsp_err}, {31'h0, err});
        chk("R1", "io_hit", {31'h0, io_hit}, {31'h0, hit});
        chk("R1", "io_write", {31'h0, io_write}, {31'h0, hit && w});
        chk("R1", "io_size", {30'h0, io_size}, hit ? {30'h0, s} : 32'h0);
        chk(sp ? "R3" : "R2", "io_addr", {16'h0, io_addr}, hit ? {16'h0, ea} : 32'h0);
        chk(s == 2'd0 ? "R5" : "R4", "io_wdata", io_wdata, (hit && w) ? fmt(wd, s, be_model) : 32'h0);
        chk(in_iack ? "R7" : (err ? "R8" : "R9"), "rsp_rdata", rsp_rdata, er);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] a;
        void'($urandom(32'd1234));
        do_reset(1'b0);
        #1;
        chk("R9", "reset rsp_err", {31'h0, rsp_err}, 32'h0);
        chk("R9", "reset rsp_rdata", rsp_rdata, 32'h0);
        chk("R1", "reset io_hit", {31'h0, io_hit}, 32'h0);

        // directed corners, little-endian
        access(1, 1, 32'h8000_1234, 2'd2, 32'hA1B2_C3D4, 0, 0, 0, 0);      // R2
        access(1, 1, 32'h807F_FFFF, 2'd1, 32'h0000_5566, 0, 0, 1, 0);      // R3 top of window
        access(1, 0, 32'h8080_0000, 2'd2, 0, 32'h1111_2222, 0, 0, 0);      // R8 just past window
        access(1, 0, 32'h7FFF_FFFF, 2'd0, 0, 0, 0, 0, 0);                  // R8 just below
        access(1, 0, 32'h8000_0003, 2'd2, 0, 32'hDEAD_BEEF, 0, 0, 0);      // R9 read
        access(1, 0, 32'hBFFF_FFF0, 2'd2, 0, 0, 32'h0000_0042, 0, 0);      // R7 vector
        access(1, 0, 32'hBFFF_FFF2, 2'd2, 0, 0, 32'h0000_0042, 0, 0);      // R7 other byte
        access(1, 1, 32'hBFFF_FFF0, 2'd2, 32'h1234_5678, 0, 32'h42, 0, 0); // R7 write ignored
        access(0, 0, 32'h1234_0000, 2'd2, 0, 0, 0, 0, 0);                  // R9 idle

        for (int i = 0; i < 300; i++) begin
            case ($urandom % 3)
                0: a = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
                1: a = 32'hBFFF_FFF0 | ($urandom & 32'h3);
                default: a = $urandom;
            endcase
            access(($urandom % 8) != 0, $urandom % 2, a, 2'($urandom % 3),
                   $urandom, $urandom, $urandom, $urandom % 2, 0);
        end

        // big-endian, then R6: change the setting after reset
        do_reset(1'b1);
        access(1, 1, 32'h8000_0010, 2'd0, 32'hAABB_CCDD, 0, 0, 0, 1);      // R5 byte unchanged
        access(1, 1, 32'h8000_0010, 2'd1, 32'hAABB_CCDD, 0, 0, 0, 1);      // R4 half
        access(1, 0, 32'hBFFF_FFF0, 2'd2, 0, 0, 32'h0102_0304, 0, 1);      // R7 swapped vector
        cfg_be = 1'b0;
        access(1, 1, 32'h8000_0020, 2'd2, 32'h0102_0304, 0, 0, 1, 1);      // R6 still big-endian
        access(1, 0, 32'h8000_0020, 2'd2, 0, 32'h0A0B_0C0D, 0, 0, 1);      // R6 read
        cfg_be = 1'b1;
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 3)
                0: a = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
                1: a = 32'hBFFF_FFF0 | ($urandom & 32'h3);
                default: a = $urandom;
            endcase
            access(($urandom % 8) != 0, $urandom % 2, a, 2'($urandom % 3),
                   $urandom, $urandom, $urandom, $urandom % 2, 1);
        end

        // back to little-endian, R6: setting high after reset ignored
        do_reset(1'b0);
        cfg_be = 1'b1;
        access(1, 1, 32'h8000_0040, 2'd2, 32'h0102_0304, 0, 0, 0, 0);      // R6

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule